// File: doc/BRIEF.md
# Held-Clock Synchronisation and Power-Down Detector

This block sits beside the serial read-out logic of a converter. It watches the serial clock input, which normally rests LOW, and at each data-ready period boundary it checks whether that clock is still held HIGH. A HIGH level that lasts over several consecutive boundaries is a command. After a short hold the block puts the modulator into reset so that several converters can be restarted together. After a long hold it also requests power-down.

When the synchronisation threshold is reached, the block takes over the shared data/ready pin. It drives the pin LOW for a fixed number of system clocks and then holds it HIGH. The normal output controller regains the pin only when the serial clock falls. That falling edge also clears the modulator reset and the power-down request. The first period boundary after release raises a one-cycle flag, which marks the first conversion result that can be trusted.

Top module: `sclk_hold_ctrl`

## Requirements
- R1: After reset, `mod_reset_o`, `pwr_down_o`, `pin_ovr_en_o`, `pin_ovr_val_o` and `first_valid_o` are all 0.
- R2: The hold count rises by one on each `period_tick_i` seen while the synchronised serial clock is HIGH. It returns to 0 on any tick seen while the clock is LOW, and on a falling edge of the serial clock. A hold that covers fewer than 4 ticks asserts neither `mod_reset_o` nor `pin_ovr_en_o`.
- R3: Once 4 consecutive ticks have been seen with the clock HIGH, `mod_reset_o` and `pin_ovr_en_o` rise together. `pin_ovr_val_o` is 0 for exactly 3 system-clock cycles, starting with the first cycle in which the override is enabled.
- R4: After the LOW pulse, `pin_ovr_val_o` is 1 while `pin_ovr_en_o` stays 1 until release. `pin_ovr_en_o` equals `mod_reset_o` on every cycle.
- R5: `pwr_down_o` is asserted only after 20 consecutive HIGH ticks. A hold of 4 to 19 ticks gives modulator reset without power-down. `pwr_down_o` implies `mod_reset_o`.
- R6: A falling edge of the serial clock clears `mod_reset_o`, `pwr_down_o`, `pin_ovr_en_o` and `pin_ovr_val_o` within a few cycles (synchroniser plus one register).
- R7: `first_valid_o` is 1 for exactly one cycle, after the first `period_tick_i` that follows a release. Later ticks do not raise it until another release.
- R8: The hold count saturates at 20. A hold far longer than 20 periods keeps `pwr_down_o` at 1 and produces no second LOW pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the reading device (asynchronous) |
| period_tick_i | input | 1 | One-cycle strobe at each data-ready period boundary |
| mod_reset_o | output | 1 | Holds the modulator in reset |
| pwr_down_o | output | 1 | Power-down request |
| pin_ovr_en_o | output | 1 | Override of the data/ready pin is active |
| pin_ovr_val_o | output | 1 | Level driven on the pin while overridden |
| first_valid_o | output | 1 | One-cycle mark of the first valid result after release |

## Verification
The checker enforces several properties on every cycle:
- the override enable tracks the modulator reset;
- power-down never appears without modulator reset;
- an override always starts LOW, and its LOW run never exceeds 3 cycles;
- the valid flag never lasts two cycles and never appears during reset;
- the hold count never passes its saturation value.

Only the bench scenarios can show the thresholds as counted in periods: nothing happens at 3 ticks, reset begins at the 4th tick, and power-down comes at the 20th and not the 19th. The same is true of a count cleared by a LOW boundary, of release by the falling edge, and of the single valid flag after release.

// File: rtl/sclk_hold_pkg.sv
package sclk_hold_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PULSE = 2'd1,
        SEQ_HOLD  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/sclk_hold_sync.sv
// Brings the asynchronous serial clock into the system domain and
// flags its falling edge.
module sclk_hold_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    output logic sclk_lvl_o,
    output logic sclk_fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], sclk_i};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk_lvl_o  = s_q.chain[STAGES-1];
    assign sclk_fall_o = s_q.prev & ~s_q.chain[STAGES-1];

endmodule

// File: rtl/sclk_hold_counter.sv
// Counts consecutive period boundaries with the serial clock HIGH and
// saturates at the power-down threshold.
module sclk_hold_counter #(
    parameter int SYNC_PERIODS = 4,
    parameter int PDN_PERIODS  = 20,
    localparam int CW          = $clog2(PDN_PERIODS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          lvl_i,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o,
    output logic          sync_hit_o,
    output logic          pdn_hit_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr_i) begin
            c_d.cnt = '0;
        end else if (tick_i) begin
            if (!lvl_i) begin
                c_d.cnt = '0;
            end else if (c_q.cnt < CW'(PDN_PERIODS)) begin
                c_d.cnt = c_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt_o      = c_q.cnt;
    assign sync_hit_o = (c_q.cnt >= CW'(SYNC_PERIODS));
    assign pdn_hit_o  = (c_q.cnt >= CW'(PDN_PERIODS));

endmodule

// File: rtl/sclk_hold_seq.sv
// Drives the pin override sequence, the modulator reset, power-down
// and the first-valid mark.
module sclk_hold_seq
    import sclk_hold_pkg::*;
#(
    parameter int LOW_CYCLES = 3,
    localparam int LW        = $clog2(LOW_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_hit_i,
    input  logic pdn_hit_i,
    input  logic fall_i,
    input  logic tick_i,
    output logic mod_reset_o,
    output logic pwr_down_o,
    output logic ovr_en_o,
    output logic ovr_val_o,
    output logic first_valid_o
);

    typedef struct packed {
        seq_state_e    st;
        logic [LW-1:0] low_cnt;
        logic          mod_rst;
        logic          pdn;
        logic          en;
        logic          val;
        logic          armed;
        logic          fv;
    } seq_t;

    seq_t q_d, q_q;

    always_comb begin
        q_d    = q_q;
        q_d.fv = 1'b0;
        unique case (q_q.st)
            SEQ_IDLE: begin
                if (q_q.armed && tick_i) begin
                    q_d.fv    = 1'b1;
                    q_d.armed = 1'b0;
                end
                if (sync_hit_i && !fall_i) begin
                    q_d.st      = SEQ_PULSE;
                    q_d.low_cnt = '0;
                    q_d.mod_rst = 1'b1;
                    q_d.en      = 1'b1;
                    q_d.val     = 1'b0;
                    q_d.armed   = 1'b0;
                    q_d.fv      = 1'b0;
                end
            end
            SEQ_PULSE, SEQ_HOLD: begin
                if (fall_i) begin
                    q_d.st      = SEQ_IDLE;
                    q_d.mod_rst = 1'b0;
                    q_d.pdn     = 1'b0;
                    q_d.en      = 1'b0;
                    q_d.val     = 1'b0;
                    q_d.armed   = 1'b1;
                end else begin
                    if (pdn_hit_i) begin
                        q_d.pdn = 1'b1;
                    end
                    if (q_q.st == SEQ_PULSE) begin
                        if (q_q.low_cnt == LW'(LOW_CYCLES - 1)) begin
                            q_d.st  = SEQ_HOLD;
                            q_d.val = 1'b1;
                        end else begin
                            q_d.low_cnt = q_q.low_cnt + 1'b1;
                        end
                    end
                end
            end
            default: begin
                q_d.st = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{st: SEQ_IDLE, default: '0};
        end else begin
            q_q <= q_d;
        end
    end

    assign mod_reset_o   = q_q.mod_rst;
    assign pwr_down_o    = q_q.pdn;
    assign ovr_en_o      = q_q.en;
    assign ovr_val_o     = q_q.val;
    assign first_valid_o = q_q.fv;

endmodule

// File: rtl/sclk_hold_ctrl.sv
module sclk_hold_ctrl #(
    parameter int SYNC_STAGES  = 2,
    parameter int SYNC_PERIODS = 4,
    parameter int PDN_PERIODS  = 20,
    parameter int LOW_CYCLES   = 3,
    localparam int CW          = $clog2(PDN_PERIODS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic period_tick_i,
    output logic mod_reset_o,
    output logic pwr_down_o,
    output logic pin_ovr_en_o,
    output logic pin_ovr_val_o,
    output logic first_valid_o
);

    logic          sclk_lvl;
    logic          sclk_fall;
    logic [CW-1:0] hold_cnt;
    logic          sync_hit;
    logic          pdn_hit;

    sclk_hold_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk_i),
        .sclk_lvl_o  (sclk_lvl),
        .sclk_fall_o (sclk_fall)
    );

    sclk_hold_counter #(
        .SYNC_PERIODS (SYNC_PERIODS),
        .PDN_PERIODS  (PDN_PERIODS)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (period_tick_i),
        .lvl_i      (sclk_lvl),
        .clr_i      (sclk_fall),
        .cnt_o      (hold_cnt),
        .sync_hit_o (sync_hit),
        .pdn_hit_o  (pdn_hit)
    );

    sclk_hold_seq #(
        .LOW_CYCLES (LOW_CYCLES)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .sync_hit_i    (sync_hit),
        .pdn_hit_i     (pdn_hit),
        .fall_i        (sclk_fall),
        .tick_i        (period_tick_i),
        .mod_reset_o   (mod_reset_o),
        .pwr_down_o    (pwr_down_o),
        .ovr_en_o      (pin_ovr_en_o),
        .ovr_val_o     (pin_ovr_val_o),
        .first_valid_o (first_valid_o)
    );

endmodule

// File: rtl/sclk_hold_chk.sv
module sclk_hold_chk #(
    parameter int PDN_PERIODS = 20,
    parameter int LOW_CYCLES  = 3,
    parameter int CW          = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mod_reset,
    input logic          pwr_down,
    input logic          ovr_en,
    input logic          ovr_val,
    input logic          first_valid,
    input logic [CW-1:0] cnt
);

    logic [7:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (ovr_en && !ovr_val) begin
            low_run <= low_run + 8'd1;
        end else begin
            low_run <= '0;
        end
    end

    // R3
    low_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_en && !ovr_val) |-> (low_run < 8'(LOW_CYCLES)));

    // R3
    override_starts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_en) |-> !ovr_val);

    // R4
    override_tracks_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_en == mod_reset);

    // R5
    pdn_needs_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> mod_reset);

    // R7
    valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid |=> !first_valid);

    // R7
    valid_outside_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid |-> !mod_reset);

    // R8
    count_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(PDN_PERIODS));

endmodule

bind sclk_hold_ctrl sclk_hold_chk #(
    .PDN_PERIODS (PDN_PERIODS),
    .LOW_CYCLES  (LOW_CYCLES),
    .CW          (CW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mod_reset   (mod_reset_o),
    .pwr_down    (pwr_down_o),
    .ovr_en      (pin_ovr_en_o),
    .ovr_val     (pin_ovr_val_o),
    .first_valid (first_valid_o),
    .cnt         (hold_cnt)
);

// File: tb/sclk_hold_ctrl_bench.sv
`timescale 1ns/1ps
module sclk_hold_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic tick = 1'b0;
    logic mod_reset, pwr_down, ovr_en, ovr_val, first_valid;

    int checks = 0;
    int failures = 0;
    int fv_count = 0;
    int pulse_count = 0;
    int low_len = 0;
    int last_low = 0;

    always #2 clk = ~clk;

    sclk_hold_ctrl u_sclk_hold_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .sclk_i        (sclk),
        .period_tick_i (tick),
        .mod_reset_o   (mod_reset),
        .pwr_down_o    (pwr_down),
        .pin_ovr_en_o  (ovr_en),
        .pin_ovr_val_o (ovr_val),
        .first_valid_o (first_valid)
    );

    // Observes the pin sequence: LOW run length, pulse count, valid marks.
    always @(negedge clk) begin
        if (first_valid) fv_count++;
        if (ovr_en && !ovr_val) begin
            if (low_len == 0) pulse_count++;
            low_len++;
        end else if (low_len != 0) begin
            last_low = low_len;
            low_len  = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic periods(input int n);
        for (int i = 0; i < n; i++) begin
            repeat (9) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 mod_reset", int'(mod_reset), 0);
        chk("R1 pwr_down", int'(pwr_down), 0);
        chk("R1 ovr_en", int'(ovr_en), 0);
        chk("R1 ovr_val", int'(ovr_val), 0);
        chk("R1 first_valid", int'(first_valid), 0);
    endtask

    task automatic t_short_hold;
        sclk = 1'b1;
        periods(3);
        settle(5);
        chk("R2 short hold mod_reset", int'(mod_reset), 0);
        chk("R2 short hold ovr_en", int'(ovr_en), 0);
        sclk = 1'b0;
        periods(2);
    endtask

    task automatic t_count_clear;
        sclk = 1'b1;
        periods(3);
        sclk = 1'b0;
        periods(1);
        sclk = 1'b1;
        periods(3);
        settle(5);
        chk("R2 cleared count mod_reset", int'(mod_reset), 0);
        sclk = 1'b0;
        periods(2);
    endtask

    task automatic t_sync_only;
        int p0;
        int f0;
        p0 = pulse_count;
        sclk = 1'b1;
        periods(4);
        settle(6);
        chk("R3 mod_reset after 4", int'(mod_reset), 1);
        chk("R3 low pulse length", last_low, 3);
        chk("R3 one pulse", pulse_count - p0, 1);
        chk("R4 hold high en", int'(ovr_en), 1);
        chk("R4 hold high val", int'(ovr_val), 1);
        periods(15);
        settle(5);
        chk("R5 no pwr_down at 19", int'(pwr_down), 0);
        chk("R4 still held at 19", int'(ovr_val & ovr_en), 1);
        f0 = fv_count;
        sclk = 1'b0;
        settle(6);
        chk("R6 release mod_reset", int'(mod_reset), 0);
        chk("R6 release ovr_en", int'(ovr_en), 0);
        chk("R7 no mark before tick", fv_count - f0, 0);
        periods(1);
        settle(2);
        chk("R7 mark after first tick", fv_count - f0, 1);
        periods(3);
        chk("R7 single mark", fv_count - f0, 1);
    endtask

    task automatic t_power_down;
        sclk = 1'b1;
        periods(19);
        settle(5);
        chk("R5 pwr_down before 20", int'(pwr_down), 0);
        periods(1);
        settle(5);
        chk("R5 pwr_down at 20", int'(pwr_down), 1);
        chk("R5 mod_reset with pdn", int'(mod_reset), 1);
        sclk = 1'b0;
        settle(6);
        chk("R6 release pwr_down", int'(pwr_down), 0);
        chk("R6 release ovr_val", int'(ovr_val), 0);
        periods(2);
    endtask

    task automatic t_long_hold;
        int p0;
        p0 = pulse_count;
        sclk = 1'b1;
        periods(45);
        settle(3);
        chk("R8 pwr_down kept", int'(pwr_down), 1);
        chk("R8 no second pulse", pulse_count - p0, 1);
        sclk = 1'b0;
        settle(6);
        chk("R6 release after long hold", int'(pwr_down | mod_reset), 0);
        periods(2);
        sclk = 1'b1;
        periods(4);
        settle(6);
        chk("R8 resync after long hold", int'(mod_reset), 1);
        sclk = 1'b0;
        periods(2);
    endtask

    task automatic summary;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        settle(3);
        t_reset();
        rst_n = 1'b1;
        settle(3);
        t_reset();
        t_short_hold();
        t_count_clear();
        t_sync_only();
        t_power_down();
        t_long_hold();
        summary();
        $finish;
    end

endmodule